// File: doc/BRIEF.md
# Hashed Page Table Walker

This block finds the translation for one effective address in a hashed page table held in memory. The caller hands it a segment description (virtual segment id, a flag for 1 TB segments, and the base page shift of the segment), the effective address, the kind of access, and the base and hash mask of the table. The walker computes a hash from the segment id and the page number. It reads the eight 16-byte entries of the selected group, and if none of them matches it reads the group at the complemented hash. It compares each entry's tag doubleword against a pattern built from the request. Only when the tag matches does it fetch the data doubleword.

On a hit the walker sets the referenced mark in the entry with a single byte write. On a store it also sets the changed mark. It then reports the entry index, the real address, and whether the page must be treated as read-only for now. A load or fetch to an entry whose changed mark is clear is reported that way, so that a later store comes back through the walker and sets the mark. Memory is reached through a one-request-at-a-time port that carries 64-bit reads and single-byte writes. Permission checking is done elsewhere.

Top module: `hpt_walker`

## Requirements
- R1: For a 256 MB segment (seg_1t=0) the hash is vsid XOR (ea[27:0] >> page shift), truncated to the hash width.
- R2: For a 1 TB segment (seg_1t=1) the hash is vsid XOR (vsid << 25) XOR (ea[39:0] >> page shift), truncated to the hash width.
- R3: The primary group is (hash AND mask). Entry index = group*8 + slot, and slots are probed in order 0 to 7. Entry byte address = table base + index*16, with the tag doubleword at +0 and the data doubleword at +8. The base is aligned to a group.
- R4: Only after all 8 primary slots fail is the group (NOT hash) AND mask probed. In that group the compare pattern requires tag bit 1 (secondary) to be set; in the primary group it must be clear.
- R5: Tag layout: bit 0 valid, bit 1 secondary, bit 2 large page, bits 6:3 unused, [37:7] abbreviated page number ((offset with the low page-shift bits cleared) >> 16), [61:38] vsid, bit 62 1 TB flag, bit 63 zero. Every bit except bits 6:2 takes part in the compare.
- R6: The tag doubleword of an entry is read first. The data doubleword is read only after a tag match, and as the very next read.
- R7: A tag match is skipped and the search continues when the size encoding is invalid. The encoding is valid when the large bit is clear and the page shift is 12, or when the large bit is set and data bits [13:12] are 1 with page shift 16, or 2 with page shift 24.
- R8: If data bit 8 (referenced) is clear, the byte at entry offset 14 (data bits 15:8, big-endian) is written with those bits ORed with 0x01. No write is made when the bit is already set.
- R9: A store (access=1) that finds data bit 7 (changed) clear writes the byte at entry offset 15 with data bits 7:0 ORed with 0x80, and reports wr_disable=0.
- R10: A load (0) or fetch (2) that finds the changed bit clear writes nothing for it and reports wr_disable=1. A miss always reports wr_disable=0.
- R11: real_addr is the data word's page number field [55:12], with the low page-shift bits replaced by the effective address bits.
- R12: If no entry matches after 16 tag reads, done is raised with hit=0, and no write is made.
- R13: After reset, done, hit, wr_disable and mem_req are low. done is a one-cycle pulse. A new memory request is never issued before the previous one has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk with the request inputs (taken while idle) |
| seg_vsid | input | VSID_W | Virtual segment id |
| seg_1t | input | 1 | 1 TB segment when set, 256 MB otherwise |
| seg_pshift | input | 6 | Base page shift of the segment (12, 16 or 24) |
| eff_addr | input | 64 | Effective address |
| access | input | 2 | 0 load, 1 store, 2 fetch |
| tbl_base | input | RA_W | Table base byte address |
| tbl_mask | input | HASH_W | Hash mask selecting the group count |
| mem_req | output | 1 | Memory request pulse |
| mem_we | output | 1 | Request is a byte write |
| mem_addr | output | RA_W | Byte address of the request |
| mem_wbyte | output | 8 | Byte to write |
| mem_ack | input | 1 | Acknowledge pulse for the outstanding request |
| mem_rdata | input | 64 | Read data, valid with mem_ack |
| done | output | 1 | Walk finished (one-cycle pulse) |
| hit | output | 1 | A matching entry was found |
| entry_idx | output | HASH_W+3 | Index of the matching entry |
| real_addr | output | RA_W | Translated real address |
| wr_disable | output | 1 | Page must be treated as not writable |

## Verification
The hardest case to reach is a tag match that has to be thrown away. This happens when an entry passes the compare but carries a size encoding that does not fit the segment, and the walk must go on to a later slot of the same group. The bench reaches it by writing its own hash into the model memory. It places an entry with a deliberately wrong large-page encoding ahead of a good one. It then checks the read count and the address order of the last two reads. Decoy entries, with a wrong secondary bit or a cleared valid bit, are placed the same way to exercise the compare.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PROBE, S_TAG, S_DATA, S_NEXT, S_SETR, S_CHG, S_SETC, S_FIN
  } walk_st_e;

  // tag doubleword bit positions
  localparam int TAG_VALID = 0;
  localparam int TAG_SEC   = 1;
  localparam int TAG_LARGE = 2;
  // data doubleword bit positions
  localparam int DAT_REF   = 8;
  localparam int DAT_CHG   = 7;
  // bits left out of the tag compare (large flag and unused bits)
  localparam logic [63:0] TAG_IGNORE = 64'h0000_0000_0000_007C;

endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
  parameter int VSID_W = 24,
  parameter int HASH_W = 28,
  parameter int API_W  = 31
) (
  input  logic [VSID_W-1:0] vsid,
  input  logic              seg1t,
  input  logic [5:0]        pshift,
  input  logic [63:0]       ea,
  output logic [HASH_W-1:0] hash,
  output logic [63:0]       pattern
);
  logic [63:0] off, pn, epn, api, h64, v64;

  always_comb begin
    v64 = 64'(vsid);
    off = seg1t ? {24'h0, ea[39:0]} : {36'h0, ea[27:0]};
    pn  = off >> pshift;
    epn = pn << pshift;
    api = epn >> 16;
    h64 = v64 ^ pn;
    if (seg1t) h64 = h64 ^ (v64 << 25);
    hash    = h64[HASH_W-1:0];
    pattern = {1'b0, seg1t, vsid, api[API_W-1:0], 7'b000_0001};
  end
endmodule

// File: rtl/hpt_entry_check.sv
module hpt_entry_check
  import hpt_pkg::*;
(
  input  logic [63:0] tag_word,
  input  logic [63:0] data_word,
  input  logic [63:0] pattern,
  input  logic        sec,
  input  logic [5:0]  pshift,
  output logic        tag_hit,
  output logic        size_ok
);
  logic [63:0] want;
  logic [1:0]  code;

  always_comb begin
    want    = pattern | (64'(sec) << TAG_SEC);
    tag_hit = ((tag_word ^ want) & ~TAG_IGNORE) == 64'h0;
    code    = data_word[13:12];
    if (tag_word[TAG_LARGE])
      size_ok = (code == 2'd1 && pshift == 6'd16) || (code == 2'd2 && pshift == 6'd24);
    else
      size_ok = (pshift == 6'd12);
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int VSID_W   = 24,
  parameter int HASH_W   = 28,
  parameter int RA_W     = 56,
  parameter int GROUP_SZ = 8,
  parameter int REF_OFS  = 14,
  localparam int SLOT_W  = $clog2(GROUP_SZ),
  localparam int IDX_W   = HASH_W + SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [VSID_W-1:0] seg_vsid,
  input  logic              seg_1t,
  input  logic [5:0]        seg_pshift,
  input  logic [63:0]       eff_addr,
  input  logic [1:0]        access,
  input  logic [RA_W-1:0]   tbl_base,
  input  logic [HASH_W-1:0] tbl_mask,
  output logic              mem_req,
  output logic              mem_we,
  output logic [RA_W-1:0]   mem_addr,
  output logic [7:0]        mem_wbyte,
  input  logic              mem_ack,
  input  logic [63:0]       mem_rdata,
  output logic              done,
  output logic              hit,
  output logic [IDX_W-1:0]  entry_idx,
  output logic [RA_W-1:0]   real_addr,
  output logic              wr_disable
);
  localparam int API_W   = 55 - VSID_W;
  localparam int PROBES  = 2 * GROUP_SZ;
  localparam int PCNT_W  = $clog2(PROBES + 1);
  localparam int CHG_OFS = 15;

  walk_st_e state;
  logic [VSID_W-1:0] vsid_q;
  logic              seg1t_q, sec_q, pend_q;
  logic [5:0]        pshift_q;
  logic [63:0]       ea_q, d0_q, d1_q;
  acc_e              acc_q;
  logic [RA_W-1:0]   base_q;
  logic [HASH_W-1:0] mask_q;
  logic [SLOT_W-1:0] slot_q;
  logic [PCNT_W-1:0] probes_q;

  logic [HASH_W-1:0] hash, grp;
  logic [63:0]       pattern, tag_word;
  logic              tag_hit, size_ok, is_store, last_slot;
  logic [IDX_W-1:0]  idx;
  logic [RA_W-1:0]   ent_addr, pmask, ra;

  hpt_hash #(.VSID_W(VSID_W), .HASH_W(HASH_W), .API_W(API_W)) u_hash (
    .vsid(vsid_q), .seg1t(seg1t_q), .pshift(pshift_q), .ea(ea_q),
    .hash(hash), .pattern(pattern)
  );

  assign tag_word = (state == S_DATA) ? d0_q : mem_rdata;

  hpt_entry_check u_chk (
    .tag_word(tag_word), .data_word(mem_rdata), .pattern(pattern),
    .sec(sec_q), .pshift(pshift_q), .tag_hit(tag_hit), .size_ok(size_ok)
  );

  always_comb begin
    grp       = sec_q ? (~hash & mask_q) : (hash & mask_q);
    idx       = {grp, slot_q};
    ent_addr  = base_q + RA_W'({idx, 4'b0000});
    pmask     = (RA_W'(1) << pshift_q) - RA_W'(1);
    ra        = ({d1_q[RA_W-1:12], 12'h000} & ~pmask) | (ea_q[RA_W-1:0] & pmask);
    is_store  = (acc_q == ACC_STORE);
    last_slot = (slot_q == SLOT_W'(GROUP_SZ - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wbyte  <= '0;
      done       <= 1'b0;
      hit        <= 1'b0;
      entry_idx  <= '0;
      real_addr  <= '0;
      wr_disable <= 1'b0;
      pend_q     <= 1'b0;
      vsid_q     <= '0;
      seg1t_q    <= 1'b0;
      pshift_q   <= 6'd12;
      ea_q       <= '0;
      acc_q      <= ACC_LOAD;
      base_q     <= '0;
      mask_q     <= '0;
      sec_q      <= 1'b0;
      slot_q     <= '0;
      probes_q   <= '0;
      d0_q       <= '0;
      d1_q       <= '0;
    end else begin
      mem_req <= 1'b0;
      done    <= 1'b0;
      pend_q  <= (pend_q | mem_req) & ~mem_ack;
      case (state)
        S_IDLE: if (start) begin
          vsid_q   <= seg_vsid;
          seg1t_q  <= seg_1t;
          pshift_q <= seg_pshift;
          ea_q     <= eff_addr;
          acc_q    <= acc_e'(access);
          base_q   <= tbl_base;
          mask_q   <= tbl_mask;
          sec_q    <= 1'b0;
          slot_q   <= '0;
          probes_q <= '0;
          state    <= S_PROBE;
        end
        S_PROBE: begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= ent_addr;
          probes_q <= probes_q + 1'b1;
          state    <= S_TAG;
        end
        S_TAG: if (mem_ack) begin
          d0_q <= mem_rdata;
          if (tag_hit) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= ent_addr + RA_W'(8);
            state    <= S_DATA;
          end else begin
            state <= S_NEXT;
          end
        end
        S_DATA: if (mem_ack) begin
          d1_q <= mem_rdata;
          if (!size_ok) begin
            state <= S_NEXT;
          end else if (!mem_rdata[DAT_REF]) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= ent_addr + RA_W'(REF_OFS);
            mem_wbyte <= mem_rdata[15:8] | 8'h01;
            state     <= S_SETR;
          end else begin
            state <= S_CHG;
          end
        end
        S_NEXT: begin
          if (!last_slot) begin
            slot_q <= slot_q + 1'b1;
            state  <= S_PROBE;
          end else if (!sec_q) begin
            sec_q  <= 1'b1;
            slot_q <= '0;
            state  <= S_PROBE;
          end else begin
            done       <= 1'b1;
            hit        <= 1'b0;
            wr_disable <= 1'b0;
            state      <= S_IDLE;
          end
        end
        S_SETR: if (mem_ack) state <= S_CHG;
        S_CHG: begin
          if (!d1_q[DAT_CHG] && is_store) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= ent_addr + RA_W'(CHG_OFS);
            mem_wbyte <= d1_q[7:0] | 8'h80;
            state     <= S_SETC;
          end else begin
            state <= S_FIN;
          end
        end
        S_SETC: if (mem_ack) state <= S_FIN;
        S_FIN: begin
          done       <= 1'b1;
          hit        <= 1'b1;
          entry_idx  <= idx;
          real_addr  <= ra;
          wr_disable <= !d1_q[DAT_CHG] && !is_store;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !pend_q); // R13
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R13
  AST_PROBE_LIMIT: assert property (@(posedge clk) disable iff (rst)
    probes_q <= PCNT_W'(PROBES)); // R12
  AST_MISS_WRITABLE: assert property (@(posedge clk) disable iff (rst)
    (done && !hit) |-> !wr_disable); // R10
  AST_MARK_BYTE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> ((mem_wbyte[0] && mem_addr[3:0] == 4'(REF_OFS)) ||
                             (mem_wbyte[7] && mem_addr[3:0] == 4'(CHG_OFS)))); // R8
endmodule

// File: tb/hpt_walker_tb.sv
module hpt_walker_tb;
  localparam logic [27:0] MASK = 28'hF;

  typedef struct packed {
    logic [23:0] vsid;
    logic        s1t;
    logic [5:0]  ps;
    logic [63:0] ea;
    logic [1:0]  acc;
    logic        sec;
    logic [2:0]  slot;
    logic [43:0] rpn;
    logic        rb;
    logic        cb;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{24'h123456, 1'b0, 6'd12, 64'h0000_0000_0ABC_D123, 2'd0, 1'b0, 3'd0, 44'h0000_0AB_CDE5, 1'b0, 1'b0},
    '{24'h00F00D, 1'b0, 6'd12, 64'h0000_0000_0765_4321, 2'd1, 1'b0, 3'd3, 44'h0000_0012_34A, 1'b0, 1'b0},
    '{24'hABCDEF, 1'b1, 6'd12, 64'h0000_00F1_2345_6789, 2'd0, 1'b1, 3'd7, 44'h0000_0077_7777, 1'b1, 1'b1},
    '{24'h5A5A5A, 1'b0, 6'd16, 64'h0000_0000_0FED_CBA9, 2'd2, 1'b0, 3'd5, 44'h0000_0088_8881, 1'b1, 1'b0},
    '{24'h0C0FFE, 1'b1, 6'd24, 64'h0000_0012_3456_789A, 2'd1, 1'b1, 3'd2, 44'h0000_0099_9992, 1'b0, 1'b1},
    '{24'h777777, 1'b0, 6'd24, 64'h0000_0000_0333_3333, 2'd0, 1'b0, 3'd7, 44'h0000_0AAA_AAA2, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [23:0] seg_vsid = '0;
  logic        seg_1t = 1'b0;
  logic [5:0]  seg_pshift = 6'd12;
  logic [63:0] eff_addr = '0;
  logic [1:0]  access = 2'd0;
  logic        mem_req, mem_we, done, hit, wr_disable;
  logic [55:0] mem_addr, real_addr;
  logic [7:0]  mem_wbyte;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic [30:0] entry_idx;

  logic [63:0] mem [256];
  int rd_cnt, wr_cnt, errors, checks;
  logic [55:0] last_rd, prev_rd;

  always #2 clk = ~clk;

  hpt_walker u_dut (
    .clk(clk), .rst(rst), .start(start), .seg_vsid(seg_vsid), .seg_1t(seg_1t),
    .seg_pshift(seg_pshift), .eff_addr(eff_addr), .access(access),
    .tbl_base(56'h0), .tbl_mask(MASK), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wbyte(mem_wbyte), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .done(done), .hit(hit), .entry_idx(entry_idx),
    .real_addr(real_addr), .wr_disable(wr_disable)
  );

  // memory model: one-cycle acknowledge, big-endian bytes within a doubleword
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr[10:3]][(7 - int'(mem_addr[2:0]))*8 +: 8] <= mem_wbyte;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[10:3]];
        rd_cnt    <= rd_cnt + 1;
        prev_rd   <= last_rd;
        last_rd   <= mem_addr;
      end
      mem_ack <= 1'b1;
    end
  end

  function automatic logic [63:0] seg_off(input logic s1t, input logic [63:0] ea);
    return s1t ? {24'h0, ea[39:0]} : {36'h0, ea[27:0]};
  endfunction

  function automatic logic [27:0] b_hash(input logic [23:0] v, input logic s1t,
                                         input logic [5:0] ps, input logic [63:0] ea);
    logic [63:0] h;
    h = {40'h0, v} ^ (seg_off(s1t, ea) >> ps);
    if (s1t) h = h ^ ({40'h0, v} << 25);
    return h[27:0];
  endfunction

  function automatic logic [63:0] mk_tag(input logic [23:0] v, input logic s1t, input logic [5:0] ps,
                                         input logic [63:0] ea, input logic lg, input logic sc);
    logic [63:0] api;
    api = ((seg_off(s1t, ea) >> ps) << ps) >> 16;
    return {1'b0, s1t, v, api[30:0], 4'b0000, lg, sc, 1'b1};
  endfunction

  function automatic int b_idx(input logic [27:0] h, input logic sc, input int slot);
    logic [27:0] g;
    g = sc ? (~h & MASK) : (h & MASK);
    return int'(g) * 8 + slot;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    @(negedge clk);
    for (int i = 0; i < 256; i++) mem[i] = 64'h0;
  endtask

  task automatic place(input int idx, input logic [63:0] tag, input logic [63:0] dat);
    mem[idx*2]     = tag;
    mem[idx*2 + 1] = dat;
  endtask

  task automatic run_lookup(input logic [23:0] v, input logic s1t, input logic [5:0] ps,
                            input logic [63:0] ea, input logic [1:0] acc);
    int n;
    @(negedge clk);
    seg_vsid = v; seg_1t = s1t; seg_pshift = ps; eff_addr = ea; access = acc;
    rd_cnt = 0; wr_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R13 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    errors = 0; checks = 0; rd_cnt = 0; wr_cnt = 0;
    for (int i = 0; i < 256; i++) mem[i] = 64'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state (R13)
    chk(!done && !hit && !wr_disable && !mem_req, "R13 reset", {done, hit, wr_disable, mem_req}, 0);

    // vector table
    for (int k = 0; k < 6; k++) begin
      vec_t v;
      logic [27:0] h;
      logic [63:0] dat, d1;
      logic [55:0] pm, exp_ra;
      int ix, exp_rd, exp_wr;
      logic st;
      v   = VEC[k];
      st  = (v.acc == 2'd1);
      h   = b_hash(v.vsid, v.s1t, v.ps, v.ea);
      ix  = b_idx(h, v.sec, int'(v.slot));
      dat = {8'h00, v.rpn, 12'h000} | (64'(v.rb) << 8) | (64'(v.cb) << 7);
      clear_mem();
      place(ix, mk_tag(v.vsid, v.s1t, v.ps, v.ea, v.ps != 6'd12, v.sec), dat);
      run_lookup(v.vsid, v.s1t, v.ps, v.ea, v.acc);
      pm     = (56'd1 << v.ps) - 56'd1;
      exp_ra = ({v.rpn, 12'h000} & ~pm) | (v.ea[55:0] & pm);
      exp_rd = (v.sec ? 8 : 0) + int'(v.slot) + 2;
      exp_wr = (v.rb ? 0 : 1) + ((!v.cb && st) ? 1 : 0);
      d1     = mem[ix*2 + 1];
      chk(done && hit, v.s1t ? (v.sec ? "R2 R4 hit" : "R2 hit") : (v.sec ? "R1 R4 hit" : "R1 hit"),
          {done, hit}, 2'b11);
      chk(entry_idx == 31'(ix), "R3 index", entry_idx, ix);
      chk(real_addr == exp_ra, "R11 real address", real_addr, exp_ra);
      chk(wr_disable == (!v.cb && !st), st ? "R9 wr_disable" : "R10 wr_disable",
          wr_disable, (!v.cb && !st));
      chk(rd_cnt == exp_rd, "R6 read count", rd_cnt, exp_rd);
      chk(wr_cnt == exp_wr, "R8 write count", wr_cnt, exp_wr);
      chk(d1[8] == 1'b1 && d1[15:9] == dat[15:9], "R8 referenced byte", d1[15:8], dat[15:8] | 8'h01);
      chk(d1[7] == (v.cb || st) && d1[6:0] == dat[6:0], st ? "R9 changed byte" : "R10 changed byte",
          d1[7:0], dat[7:0] | {(v.cb || st), 7'h0});
    end

    // R12: empty table gives a miss after 16 tag reads
    begin
      clear_mem();
      run_lookup(24'h00ABCD, 1'b0, 6'd12, 64'h0000_0000_0123_4000, 2'd1);
      chk(done && !hit, "R12 miss", {done, hit}, 2'b10);
      chk(rd_cnt == 16, "R12 probe count", rd_cnt, 16);
      chk(wr_cnt == 0, "R12 no write", wr_cnt, 0);
      chk(!wr_disable, "R10 miss writable", wr_disable, 0);
    end

    // R7: matching tag with a bad size encoding is skipped
    begin
      logic [27:0] h;
      logic [63:0] ea;
      int i1, i4;
      ea = 64'h0000_0000_0123_4567;
      h  = b_hash(24'h111111, 1'b0, 6'd16, ea);
      i1 = b_idx(h, 1'b0, 1);
      i4 = b_idx(h, 1'b0, 4);
      clear_mem();
      place(i1, mk_tag(24'h111111, 1'b0, 6'd16, ea, 1'b0, 1'b0), {8'h0, 44'h0000_0055_5551, 12'h180});
      place(i4, mk_tag(24'h111111, 1'b0, 6'd16, ea, 1'b1, 1'b0), {8'h0, 44'h0000_0066_6661, 12'h180});
      run_lookup(24'h111111, 1'b0, 6'd16, ea, 2'd0);
      chk(hit && entry_idx == 31'(i4), "R7 skip bad size", entry_idx, i4);
      chk(rd_cnt == 7, "R7 read count", rd_cnt, 7);
      chk(prev_rd == 56'(i4 * 16) && last_rd == 56'(i4 * 16 + 8), "R6 tag then data",
          {prev_rd[31:0], last_rd[31:0]}, {32'(i4 * 16), 32'(i4 * 16 + 8)});
    end

    // R4/R5: decoys with wrong secondary bit or no valid bit; unused bits ignored
    begin
      logic [27:0] h;
      logic [63:0] ea, tg;
      int i0, i1, i2;
      ea = 64'h0000_0000_0555_5000;
      h  = b_hash(24'h222222, 1'b0, 6'd12, ea);
      i0 = b_idx(h, 1'b0, 0);
      i1 = b_idx(h, 1'b0, 1);
      i2 = b_idx(h, 1'b0, 2);
      tg = mk_tag(24'h222222, 1'b0, 6'd12, ea, 1'b0, 1'b0);
      clear_mem();
      place(i0, tg | 64'h2, {8'h0, 44'h1, 12'h180});
      place(i1, tg & ~64'h1, {8'h0, 44'h2, 12'h180});
      place(i2, tg | 64'h78, {8'h0, 44'h0000_0033_3333, 12'h180});
      run_lookup(24'h222222, 1'b0, 6'd12, ea, 2'd2);
      chk(hit && entry_idx == 31'(i2), "R4 R5 decoys skipped", entry_idx, i2);
      chk(rd_cnt == 4, "R5 read count", rd_cnt, 4);
      chk(wr_cnt == 0 && !wr_disable, "R8 marks already set", {wr_cnt[7:0], wr_disable}, 0);
      @(negedge clk);
      chk(!done, "R13 done pulse", done, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule